// File: doc/BRIEF.md
# Prescaled Compare Timer with Edge Capture

This block is a general-purpose timer on a small 32-bit register bus. A 16-bit up-counter advances once per prescaler tick, where the prescaler divides the system clock by a power of two chosen by a 4-bit code. When the count reaches a programmable compare value, the timer either wraps to zero and carries on, or stops with its run bit cleared in single-shot mode. Loading the compare value with all ones gives a free-running counter over the whole 16-bit range.

One external pin feeds an input-capture unit. The pin is synchronized, its edges are detected, and each selected edge copies the current count into its own latch: one for rising edges and one for falling edges. Compare matches and captures set sticky status flags that software clears by writing ones. Each flag has its own enable into a single interrupt line.

Software sees six word registers that start at byte offset 0x80. Everything below that offset reads as zero and ignores writes.

Top module: `capture_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` is low. The timer is therefore stopped, in auto-reload mode, with a divide-by-1 prescaler. Addresses below 0x80 read zero.
- R2: Registers sit at byte offsets 0x80 control, 0x84 status, 0x88 compare, 0x8C count, 0x90 rising capture and 0x94 falling capture. Compare reads back what was written. The count register is read-only and a write to it has no effect.
- R3: Control bits 3:0 hold a prescaler code n, and the counter advances once every 2^n clock cycles while running. Codes above 8 behave as 8. The first advance lands 2^n cycles after the write that sets the run bit.
- R4: With control bit 4 clear (auto-reload), a tick that finds the count equal to the compare value loads zero, so the count period is compare+1 ticks. A compare value of 0xFFFF runs over the full 16-bit range.
- R5: With control bit 4 set (single-shot), the tick that finds the count equal to the compare value leaves the count at the compare value and clears the run bit (control bit 5). A control write in that same cycle wins.
- R6: While the run bit is clear, the count holds its value.
- R7: A tick that finds the count equal to the compare value sets status bit 0.
- R8: Control bits 7:6 select capture: 00 off, 01 rising, 10 falling, 11 both. The pin passes through two synchronizing flops. For a level first sampled at edge A, the count present after edge A+1 is latched at edge A+2. A rising edge loads the rising capture register and sets status bit 2. A falling edge loads the falling capture register and sets status bit 1. Capture works whether or not the timer runs.
- R9: An edge that the capture mode does not select changes neither capture register nor any status bit.
- R10: Writing a one to a status bit clears it. Writing a zero leaves it unchanged. A new event in the same cycle as the clear keeps the bit set.
- R11: `irq` is high exactly when some status bit is set and its enable is set: control bit 8 for match, bit 9 for falling capture, bit 10 for rising capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W (8) | Byte address, used for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_addr` |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request, level sensitive |

## Verification
The assertions check these rules on every cycle:
- a single-shot match clears the run bit;
- a stopped counter holds its count;
- a match always sets its flag;
- a write-one clear drops the match flag when no new match arrives;
- the rising capture latch changes only after a detected rising edge;
- the interrupt is never raised while every status flag is clear.

Some behaviours need the bench's scenarios:
- the exact counts reached for each prescaler code and mode;
- the clamping of codes above 8;
- the cycle alignment of a capture taken while the counter runs;
- whether an unselected edge is ignored;
- whether each interrupt enable masks its own flag.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CNT_W      = 16;
    localparam int DATA_W     = 32;
    localparam int CODE_W     = 4;
    localparam int MAX_CODE   = 8;
    localparam int PRE_W      = MAX_CODE;
    localparam int WIN_BASE   = 'h80;
    localparam int NUM_REGS   = 6;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic              ie_rise;
        logic              ie_fall;
        logic              ie_match;
        logic [1:0]        cap_sel;
        logic              run;
        logic              one_shot;
        logic [CODE_W-1:0] presc;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic rise;
        logic fall;
        logic match;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_STAT = 3'd1,
        SEL_CMP  = 3'd2,
        SEL_CNT  = 3'd3,
        SEL_CAPR = 3'd4,
        SEL_CAPF = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_BOTH = 2'b11
    } cap_mode_e;

    // Mask of prescaler phase bits that must all be one for a tick.
    function automatic logic [PRE_W-1:0] div_mask(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] eff;
        logic [PRE_W:0]    m;
        eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        m   = ((PRE_W+1)'(1) << eff) - (PRE_W+1)'(1);
        return m[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = div_mask(code);
        tick = run && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter
    import ctmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             one_shot,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             match_evt,
    output logic             done
);
    logic [CNT_W-1:0] count_q;
    logic             at_cmp;

    always_comb begin
        at_cmp    = (count_q == cmp);
        match_evt = tick && at_cmp;
        done      = match_evt && one_shot;
        count     = count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick) begin
            if (at_cmp) begin
                count_q <= one_shot ? count_q : '0;
            end else begin
                count_q <= count_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ctmr_capture.sv
module ctmr_capture
    import ctmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    output logic             rise_evt,
    output logic             fall_evt,
    output logic [CNT_W-1:0] cap_rise,
    output logic [CNT_W-1:0] cap_fall
);
    // Stages 0..SYNC_STAGES-1 synchronize, the last holds the previous level.
    logic [SYNC_STAGES:0] sync_q;
    logic                 level;
    logic                 prev;
    logic [1:0]           evt;
    logic [CNT_W-1:0]     cap_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], pin};
        end
    end

    always_comb begin
        level  = sync_q[SYNC_STAGES-1];
        prev   = sync_q[SYNC_STAGES];
        evt[0] = level && !prev && mode[0];
        evt[1] = !level && prev && mode[1];
    end

    for (genvar e = 0; e < 2; e++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q[e] <= '0;
            end else if (evt[e]) begin
                cap_q[e] <= count;
            end
        end
    end

    assign rise_evt = evt[0];
    assign fall_evt = evt[1];
    assign cap_rise = cap_q[0];
    assign cap_fall = cap_q[1];
endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ctmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin,
    output logic              irq
);
    ctrl_t            ctrl_q;
    stat_t            stat_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap_r;
    logic [CNT_W-1:0] cap_f;
    logic             tick;
    logic             match_evt;
    logic             done;
    logic             rise_evt;
    logic             fall_evt;

    logic [ADDR_W-1:0] off;
    logic              in_win;
    reg_sel_e          sel;
    logic              ctrl_wr;
    logic              stat_wr;
    logic              cmp_wr;
    stat_t             stat_set;
    stat_t             stat_clr;
    logic              unused_bits;

    // Address decode
    always_comb begin
        off     = bus_addr - ADDR_W'(WIN_BASE);
        in_win  = (bus_addr >= ADDR_W'(WIN_BASE)) && (off < ADDR_W'(NUM_REGS * 4));
        sel     = reg_sel_e'(off[4:2]);
        ctrl_wr = bus_wr && in_win && (sel == SEL_CTRL);
        stat_wr = bus_wr && in_win && (sel == SEL_STAT);
        cmp_wr  = bus_wr && in_win && (sel == SEL_CMP);
    end

    assign unused_bits = &{1'b0, bus_wdata[DATA_W-1:CNT_W], off[1:0], off[ADDR_W-1:5]};

    // Control register: a bus write wins over a single-shot stop
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end else if (done) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Sticky status, write-one-to-clear, new events win
    always_comb begin
        stat_set.match = match_evt;
        stat_set.fall  = fall_evt;
        stat_set.rise  = rise_evt;
        stat_clr       = stat_wr ? stat_t'(bus_wdata[STAT_W-1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
        end
    end

    assign irq = |(stat_q & {ctrl_q.ie_rise, ctrl_q.ie_fall, ctrl_q.ie_match});

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            unique case (sel)
                SEL_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
                SEL_STAT: bus_rdata[STAT_W-1:0] = stat_q;
                SEL_CMP:  bus_rdata[CNT_W-1:0]  = cmp_q;
                SEL_CNT:  bus_rdata[CNT_W-1:0]  = count;
                SEL_CAPR: bus_rdata[CNT_W-1:0]  = cap_r;
                SEL_CAPF: bus_rdata[CNT_W-1:0]  = cap_f;
                default:  bus_rdata = '0;
            endcase
        end
    end

    ctmr_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .code (ctrl_q.presc),
        .tick (tick)
    );

    ctmr_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .one_shot  (ctrl_q.one_shot),
        .cmp       (cmp_q),
        .count     (count),
        .match_evt (match_evt),
        .done      (done)
    );

    ctmr_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .pin      (cap_pin),
        .mode     (ctrl_q.cap_sel),
        .count    (count),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .cap_rise (cap_r),
        .cap_fall (cap_f)
    );
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk
    import ctmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input ctrl_t            ctrl_q,
    input stat_t            stat_q,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             done,
    input logic             ctrl_wr,
    input logic             stat_wr,
    input logic             clr_match,
    input logic             match_evt,
    input logic             rise_evt,
    input logic [CNT_W-1:0] cap_r
);
    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != '0));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ctrl_wr) |=> !ctrl_q.run);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run |=> $stable(count));

    // R7
    match_flag_chk: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> stat_q.match);

    // R10
    w1c_match_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && clr_match && !match_evt) |=> !stat_q.match);

    // R8
    cap_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_r) |-> $past(rise_evt));
endmodule

bind capture_timer capture_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .count     (count),
    .irq       (irq),
    .done      (done),
    .ctrl_wr   (ctrl_wr),
    .stat_wr   (stat_wr),
    .clr_match (bus_wdata[0]),
    .match_evt (match_evt),
    .rise_evt  (rise_evt),
    .cap_r     (cap_r)
);

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;

    localparam logic [7:0] A_CTRL = 8'h80;
    localparam logic [7:0] A_STAT = 8'h84;
    localparam logic [7:0] A_CMP  = 8'h88;
    localparam logic [7:0] A_CNT  = 8'h8C;
    localparam logic [7:0] A_CAPR = 8'h90;
    localparam logic [7:0] A_CAPF = 8'h94;

    typedef struct packed {
        logic [3:0]  code;
        logic        os;
        logic [15:0] cmp;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd0,  1'b0, 16'd100,    16'd10},
        '{4'd2,  1'b0, 16'd100,    16'd40},
        '{4'd3,  1'b0, 16'd100,    16'd81},
        '{4'd0,  1'b0, 16'd5,      16'd14},
        '{4'd0,  1'b1, 16'd5,      16'd14},
        '{4'd8,  1'b0, 16'hFFFF,   16'd600},
        '{4'd12, 1'b0, 16'hFFFF,   16'd600},
        '{4'd1,  1'b1, 16'd3,      16'd20}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_pin = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;
    logic [31:0] frozen;

    always #5 clk = ~clk;

    capture_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_pin   (cap_pin),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cap_pin = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();

        // R1 reset state
        rd(A_CTRL, rv); check("R1 ctrl", rv, 32'h0);
        rd(A_STAT, rv); check("R1 status", rv, 32'h0);
        rd(A_CMP,  rv); check("R1 compare", rv, 32'h0);
        rd(A_CNT,  rv); check("R1 count", rv, 32'h0);
        rd(A_CAPR, rv); check("R1 rise cap", rv, 32'h0);
        rd(A_CAPF, rv); check("R1 fall cap", rv, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h10, rv); check("R1 reserved", rv, 32'h0);

        // R2 map, compare readback, read-only count
        wr(A_CMP, 32'h0000_1234);
        rd(A_CMP, rv); check("R2 compare", rv, 32'h1234);
        wr(A_CNT, 32'h0000_0055);
        rd(A_CNT, rv); check("R2 count read-only", rv, 32'h0);

        // Vector table: R3 prescaler, R4 auto-reload, R5 single-shot
        for (int i = 0; i < 8; i++) begin
            int eff;
            int t;
            int exp;
            string req;
            do_reset();
            wr(A_CMP, {16'h0, VECS[i].cmp});
            wr(A_CTRL, {27'h0, VECS[i].os, 4'h0} | 32'h20 | {28'h0, VECS[i].code});
            wait_n(int'(VECS[i].cyc));
            eff = (VECS[i].code > 4'd8) ? 8 : int'(VECS[i].code);
            t = int'(VECS[i].cyc) >> eff;
            if (VECS[i].os) exp = (t > int'(VECS[i].cmp)) ? int'(VECS[i].cmp) : t;
            else            exp = t % (int'(VECS[i].cmp) + 1);
            req = VECS[i].os ? "R5" : ((t > int'(VECS[i].cmp)) ? "R4" : "R3");
            rd(A_CNT, rv);
            check(req, rv, 32'(exp));
        end

        // R5 single-shot clears run bit, R7 match flag, R11 irq
        do_reset();
        wr(A_CMP, 32'd2);
        wr(A_CTRL, 32'h130);
        wait_n(10);
        rd(A_CTRL, rv); check("R5 run cleared", rv, 32'h110);
        rd(A_CNT,  rv); check("R5 count held", rv, 32'd2);
        rd(A_STAT, rv); check("R7 match flag", rv, 32'h1);
        check("R11 irq match", {31'h0, irq}, 32'h1);
        wait_n(5);
        rd(A_CNT, rv); check("R6 stopped hold", rv, 32'd2);

        // R10 write-one-to-clear
        wr(A_STAT, 32'h0);
        rd(A_STAT, rv); check("R10 zero write", rv, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, rv); check("R10 clear", rv, 32'h0);
        check("R11 irq cleared", {31'h0, irq}, 32'h0);

        // R11 masked match
        do_reset();
        wr(A_CMP, 32'd2);
        wr(A_CTRL, 32'h20);
        wait_n(10);
        rd(A_STAT, rv); check("R7 flag unmasked", rv[0] ? 32'h1 : 32'h0, 32'h1);
        check("R11 masked", {31'h0, irq}, 32'h0);

        // R8 rising capture while running
        do_reset();
        wr(A_CMP, 32'hFFFF);
        wr(A_CTRL, 32'h460);
        wait_n(5);
        cap_pin = 1'b1;
        wait_n(3);
        rd(A_CAPR, rv); check("R8 rise count", rv, 32'd7);
        rd(A_STAT, rv); check("R8 rise flag", rv, 32'h4);
        check("R11 irq rise", {31'h0, irq}, 32'h1);
        cap_pin = 1'b0;
        wait_n(4);
        rd(A_CAPF, rv); check("R9 fall ignored", rv, 32'h0);
        rd(A_STAT, rv); check("R9 fall flag clear", rv, 32'h4);

        // R8 both edges on a stopped counter
        wr(A_CTRL, 32'hC0);
        rd(A_CNT, frozen);
        cap_pin = 1'b1;
        wait_n(4);
        rd(A_CAPR, rv); check("R8 rise stopped", rv, frozen);
        cap_pin = 1'b0;
        wait_n(4);
        rd(A_CAPF, rv); check("R8 fall stopped", rv, frozen);
        rd(A_STAT, rv); check("R8 both flags", rv, 32'h6);

        // R9 capture off
        wr(A_STAT, 32'h7);
        wr(A_CTRL, 32'h0);
        cap_pin = 1'b1;
        wait_n(4);
        cap_pin = 1'b0;
        wait_n(4);
        rd(A_STAT, rv); check("R9 mode off", rv, 32'h0);

        // R9 falling-only ignores rise, R11 fall enable
        do_reset();
        wr(A_CTRL, 32'h280);
        cap_pin = 1'b1;
        wait_n(4);
        rd(A_STAT, rv); check("R9 rise ignored", rv, 32'h0);
        cap_pin = 1'b0;
        wait_n(4);
        rd(A_STAT, rv); check("R8 fall flag", rv, 32'h2);
        check("R11 irq fall", {31'h0, irq}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule